// File: doc/BRIEF.md
# Indexed RTC Register Access Port

This block is the host-facing front end of a real-time clock. The host reaches every location in two steps. It first loads a location number into an index register, then reads or writes the selected byte through a data port. The index stays loaded, so several data accesses in a row go to the same location.

Locations 0 to 13 are the clock and control registers:

- Ten time and alarm bytes.
- A rate/divider control byte, whose top bit is a read-only update-busy status.
- A mode control byte holding the interrupt enables.
- An interrupt flag byte that clears when it is read.
- A validity byte that reports only its top bit.

Locations 14 to 63 are fifty bytes of general storage. The block drives the time/alarm bytes and the control fields towards the time counter and the interrupt logic. It collects update-busy, validity and event pulses from that logic.

Top module: `rtc_index_port`

## Requirements
- R1: A pulse on `idx_wr` loads `wdata[5:0]` into the index; `wdata[7:6]` are ignored. The index holds its value across any number of data accesses until `idx_wr` is pulsed again.
- R2: A data write to locations 0 to 9 stores the byte. It reads back unchanged and appears on `tod_regs[8*n +: 8]` one cycle after the write.
- R3: At location 10, bits 6:0 are writable. They drive `div_sel` (bits 6:4) and `rate_sel` (bits 3:0). Bit 7 reads the level of `upd_busy`, and writes to bit 7 are dropped.
- R4: Location 11 is fully read/write and drives `ctrl_b`. Bit 6 enables the periodic interrupt, bit 5 the alarm interrupt and bit 4 the update-end interrupt.
- R5: Location 12 reads the following fields:
  - Bits 6, 5 and 4 are the periodic, alarm and update-end flags. A pulse on `flag_set[2]`, `flag_set[1]` or `flag_set[0]` sets the matching flag, and the flag stays set.
  - Bit 7 is high when any flag is set together with its enable.
  - Bits 3:0 read zero.
  - `irq` equals bit 7.
- R6: A data read of location 12 returns the flags and clears all of them at the same clock edge. A flag whose `flag_set` pulse arrives in that same cycle stays set.
- R7: Data writes to locations 12 and 13 change nothing.
- R8: Location 13 reads `{vrt_in, 7'b0}`.
- R9: Locations 14 to 63 are fifty independent read/write storage bytes.
- R10: Read data appears on `rdata` in the cycle after a `data_rd` pulse and holds until the next read.
- R11: After reset, the following read zero:
  - the index;
  - every register and storage byte;
  - `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idx_wr | input | 1 | Load index from wdata |
| data_wr | input | 1 | Write wdata to the indexed location |
| data_rd | input | 1 | Read the indexed location into rdata |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered read data |
| upd_busy | input | 1 | Update-in-progress status from the time counter |
| vrt_in | input | 1 | Valid RAM and time status |
| flag_set | input | 3 | Event pulses: periodic, alarm, update-end |
| tod_regs | output | 80 | Time and alarm bytes, location n at bits 8n+7:8n |
| rate_sel | output | 4 | Periodic rate select |
| div_sel | output | 3 | Divider select |
| ctrl_b | output | 8 | Mode control byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The results arrive at these cycles:
- A write lands at the clock edge that samples its strobe, so `tod_regs`, `rate_sel`, `div_sel` and `ctrl_b` change one edge after the strobe.
- `rdata` carries a read's value after that same edge.
- A flag pulse shows on `irq` one edge after the pulse.

The bench drives every strobe on the falling edge and drops it on the next falling edge. It compares only then, half a cycle after the edge that produced the result. The sweeps visit every location with arithmetic patterns under two settings of the status inputs. The flag tests put a set pulse and a clearing read in the same cycle.

// File: rtl/rtc_port_pkg.sv
// Package: shared sizes and location map of the indexed RTC register port.
// Assumes byte-wide data and a six-bit index covering 64 locations.
package rtc_port_pkg;
    localparam int DATA_W      = 8;
    localparam int IDX_W       = 6;
    localparam int NUM_TOD     = 10;
    localparam int LOC_CTRL_A  = 10;
    localparam int LOC_CTRL_B  = 11;
    localparam int LOC_FLAGS   = 12;
    localparam int LOC_VALID   = 13;
    localparam int STORE_BASE  = 14;
    localparam int STORE_BYTES = 50;
    localparam int NUM_EVT     = 3;
endpackage

// File: rtl/rtc_index_reg.sv
// Module: index register. Captures the low IDX_W bits of the host byte on a
// load pulse and holds them otherwise. Assumes IDX_W <= DATA_W.
module rtc_index_reg #(
    parameter int IDX_W  = rtc_port_pkg::IDX_W,
    parameter int DATA_W = rtc_port_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  idx
);
    // Hold the selected location until the host loads a new one.
    always_ff @(posedge clk) begin
        if (!rst_n)    idx <= '0;
        else if (load) idx <= wdata[IDX_W-1:0];
    end
endmodule

// File: rtl/rtc_ctrl_regs.sv
// Module: clock and control registers (locations 0..13). Holds the time and
// alarm bytes, the rate/divider byte, the mode byte and the sticky event flags.
// It builds the merged read value of these registers. Assumes byte-wide data;
// the flag and enable bit positions are fixed by the register layout.
module rtc_ctrl_regs #(
    parameter int IDX_W   = rtc_port_pkg::IDX_W,
    parameter int NUM_TOD = rtc_port_pkg::NUM_TOD,
    parameter int NUM_EVT = rtc_port_pkg::NUM_EVT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [IDX_W-1:0]      idx,
    input  logic [7:0]            wdata,
    input  logic                  upd_busy,
    input  logic                  vrt_in,
    input  logic [NUM_EVT-1:0]    flag_set,
    output logic [NUM_TOD*8-1:0]  tod_flat,
    output logic [6:0]            ctrl_a,
    output logic [7:0]            ctrl_b,
    output logic [NUM_EVT-1:0]    flags,
    output logic                  irq,
    output logic                  hit,
    output logic [7:0]            rd_val
);
    import rtc_port_pkg::*;

    localparam logic [IDX_W-1:0] IDX_A = IDX_W'(LOC_CTRL_A);
    localparam logic [IDX_W-1:0] IDX_B = IDX_W'(LOC_CTRL_B);
    localparam logic [IDX_W-1:0] IDX_C = IDX_W'(LOC_FLAGS);
    localparam logic [IDX_W-1:0] IDX_D = IDX_W'(LOC_VALID);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(STORE_BASE);

    logic [7:0] tod_q [NUM_TOD];
    logic       irqf;

    // One writable byte per time/alarm location.
    for (genvar g = 0; g < NUM_TOD; g++) begin : g_tod
        // Store the host byte when this location is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                             tod_q[g] <= '0;
            else if (wr_en && idx == IDX_W'(g))     tod_q[g] <= wdata;
        end
        assign tod_flat[g*8 +: 8] = tod_q[g];
    end

    // Rate/divider byte: the busy bit is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ctrl_a <= '0;
        else if (wr_en && idx == IDX_A)  ctrl_a <= wdata[6:0];
    end

    // Mode byte: fully writable.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ctrl_b <= '0;
        else if (wr_en && idx == IDX_B)  ctrl_b <= wdata;
    end

    // Sticky flags: a read clears them, and a pulse in the same cycle survives.
    always_ff @(posedge clk) begin
        if (!rst_n)                      flags <= '0;
        else if (rd_en && idx == IDX_C)  flags <= flag_set;
        else                             flags <= flags | flag_set;
    end

    // Request when any flag meets its enable in mode byte bits 6:4.
    always_comb begin
        irqf = |(flags & ctrl_b[6:4]);
        irq  = irqf;
        hit  = idx < IDX_END;
    end

    // Merge stored bytes and live status into the read value.
    always_comb begin
        rd_val = '0;
        if (idx < IDX_W'(NUM_TOD))  rd_val = tod_q[idx[3:0]];
        else if (idx == IDX_A)      rd_val = {upd_busy, ctrl_a};
        else if (idx == IDX_B)      rd_val = ctrl_b;
        else if (idx == IDX_C)      rd_val = {irqf, flags, 4'b0000};
        else if (idx == IDX_D)      rd_val = {vrt_in, 7'b0};
    end
endmodule

// File: rtl/rtc_byte_store.sv
// Module: general byte storage placed directly after the clock registers.
// Each byte answers to its own location and reads as zero elsewhere.
// Assumes BASE + DEPTH fits in the index width.
module rtc_byte_store #(
    parameter int IDX_W  = rtc_port_pkg::IDX_W,
    parameter int DATA_W = rtc_port_pkg::DATA_W,
    parameter int BASE   = rtc_port_pkg::STORE_BASE,
    parameter int DEPTH  = rtc_port_pkg::STORE_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val
);
    logic [DATA_W-1:0] mem [DEPTH];

    // One register per storage byte.
    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        // Store the host byte when this location is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                               mem[g] <= '0;
            else if (wr_en && idx == IDX_W'(BASE + g)) mem[g] <= wdata;
        end
    end

    // Select the addressed byte, or zero when outside the storage range.
    always_comb begin
        rd_val = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (idx == IDX_W'(BASE + k)) rd_val = mem[k];
        end
    end
endmodule

// File: rtl/rtc_index_port.sv
// Module: top of the indexed RTC register port. Ties the index register, the
// clock/control registers and the byte storage together. It registers the
// read data. Assumes the host issues one strobe per cycle; a data strobe in
// the cycle that loads the index uses the old index.
module rtc_index_port #(
    parameter int IDX_W   = rtc_port_pkg::IDX_W,
    parameter int DATA_W  = rtc_port_pkg::DATA_W,
    parameter int NUM_TOD = rtc_port_pkg::NUM_TOD,
    parameter int NUM_EVT = rtc_port_pkg::NUM_EVT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    idx_wr,
    input  logic                    data_wr,
    input  logic                    data_rd,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    input  logic                    upd_busy,
    input  logic                    vrt_in,
    input  logic [NUM_EVT-1:0]      flag_set,
    output logic [NUM_TOD*8-1:0]    tod_regs,
    output logic [3:0]              rate_sel,
    output logic [2:0]              div_sel,
    output logic [7:0]              ctrl_b,
    output logic                    irq
);
    logic [IDX_W-1:0]   idx_q;
    logic [6:0]         ctrl_a_w;
    logic [NUM_EVT-1:0] flags_w;
    logic               ctrl_hit;
    logic [7:0]         ctrl_val;
    logic [DATA_W-1:0]  store_val;

    rtc_index_reg #(.IDX_W(IDX_W), .DATA_W(DATA_W)) idx_i (
        .clk(clk), .rst_n(rst_n), .load(idx_wr), .wdata(wdata), .idx(idx_q)
    );

    rtc_ctrl_regs #(.IDX_W(IDX_W), .NUM_TOD(NUM_TOD), .NUM_EVT(NUM_EVT)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .rd_en(data_rd),
        .idx(idx_q), .wdata(wdata[7:0]), .upd_busy(upd_busy), .vrt_in(vrt_in),
        .flag_set(flag_set), .tod_flat(tod_regs), .ctrl_a(ctrl_a_w),
        .ctrl_b(ctrl_b), .flags(flags_w), .irq(irq), .hit(ctrl_hit),
        .rd_val(ctrl_val)
    );

    rtc_byte_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .idx(idx_q),
        .wdata(wdata), .rd_val(store_val)
    );

    assign rate_sel = ctrl_a_w[3:0];
    assign div_sel  = ctrl_a_w[6:4];

    // Capture the selected location on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata <= '0;
        else if (data_rd)  rdata <= ctrl_hit ? DATA_W'(ctrl_val) : store_val;
    end
endmodule

// File: rtl/rtc_index_port_chk.sv
// Module: assertion checker for the indexed RTC register port, bound to the top.
module rtc_index_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       idx_wr,
    input logic       data_wr,
    input logic       data_rd,
    input logic [5:0] idx,
    input logic [2:0] flags,
    input logic [2:0] flag_set,
    input logic [7:0] rdata,
    input logic       vrt_in
);
    // R1: the index only moves on a load pulse.
    p_idx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> $stable(idx));

    // R6: reading the flag byte with no new event leaves all flags clear.
    p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && idx == 6'd12 && flag_set == 3'b000) |=> flags == 3'b000);

    // R7: writing the flag byte does not clear flags.
    p_flag_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !data_rd && idx == 6'd12) |=> ((flags & $past(flags)) == $past(flags)));

    // R5: low nibble of the flag byte reads zero.
    p_flag_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && idx == 6'd12) |=> rdata[3:0] == 4'b0000);

    // R8: validity byte reads the status input in the top bit only.
    p_valid_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && idx == 6'd13) |=> rdata == {$past(vrt_in), 7'b0});

    // R10: read data holds between read strobes.
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !data_rd |=> $stable(rdata));
endmodule

bind rtc_index_port rtc_index_port_chk chk_i (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
    .data_rd(data_rd), .idx(idx_q), .flags(flags_w), .flag_set(flag_set),
    .rdata(rdata), .vrt_in(vrt_in)
);

// File: tb/rtc_index_port_tb_top.sv
`timescale 1ns/1ps
module rtc_index_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        upd_busy = 1'b0, vrt_in = 1'b0;
    logic [2:0]  flag_set = '0;
    logic [79:0] tod_regs;
    logic [3:0]  rate_sel;
    logic [2:0]  div_sel;
    logic [7:0]  ctrl_b;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rtc_index_port dut_i (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
        .data_rd(data_rd), .wdata(wdata), .rdata(rdata), .upd_busy(upd_busy),
        .vrt_in(vrt_in), .flag_set(flag_set), .tod_regs(tod_regs),
        .rate_sel(rate_sel), .div_sel(div_sel), .ctrl_b(ctrl_b), .irq(irq)
    );

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_idx(input logic [7:0] v);
        @(negedge clk); idx_wr = 1'b1; wdata = v;
        @(negedge clk); idx_wr = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk); data_wr = 1'b1; wdata = v;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic rd_data(output logic [7:0] v);
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0; v = rdata;
    endtask

    task automatic pulse_evt(input logic [2:0] e);
        @(negedge clk); flag_set = e;
        @(negedge clk); flag_set = 3'b000;
    endtask

    function automatic logic [7:0] pat(input int i, input int p);
        return 8'((i * 37 + 5 + p * 91) & 255);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp_v;
        logic [79:0] exp_tod;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state at the ports and through reads.
        check("R11 rdata", rdata, 0);
        check("R11 tod", tod_regs, 0);
        check("R11 ctrl_b", ctrl_b, 0);
        check("R11 irq", irq, 0);
        rd_data(v); check("R11 index0 read", v, 0);
        set_idx(8'd40); rd_data(v); check("R11 store40 read", v, 0);

        // Two full sweeps over every location (R2 R3 R4 R5 R7 R8 R9).
        for (int p = 0; p < 2; p++) begin
            upd_busy = p[0];
            vrt_in = ~p[0];
            for (int i = 0; i < 64; i++) begin
                set_idx(8'(i)); wr_data(pat(i, p));
            end
            for (int i = 0; i < 64; i++) begin
                set_idx(8'(i)); rd_data(v);
                if (i == 10)      exp_v = {upd_busy, pat(i, p)[6:0]};
                else if (i == 12) exp_v = 8'h00;
                else if (i == 13) exp_v = {vrt_in, 7'b0};
                else              exp_v = pat(i, p);
                if (i < 10)       check("R2 time byte", v, exp_v);
                else if (i == 10) check("R3 rate byte", v, exp_v);
                else if (i == 11) check("R4 mode byte", v, exp_v);
                else if (i == 12) check("R7 flag byte write ignored", v, exp_v);
                else if (i == 13) check("R8 valid byte", v, exp_v);
                else              check("R9 storage byte", v, exp_v);
            end
            for (int i = 0; i < 10; i++) exp_tod[i*8 +: 8] = pat(i, p);
            check("R2 tod_regs", tod_regs, exp_tod);
            check("R3 rate_sel", rate_sel, pat(10, p)[3:0]);
            check("R3 div_sel", div_sel, pat(10, p)[6:4]);
            check("R4 ctrl_b", ctrl_b, pat(11, p));
        end

        // R1: index held across several accesses; upper bits ignored.
        set_idx(8'd20); wr_data(8'h5A); rd_data(v); check("R1 hold read1", v, 8'h5A);
        rd_data(v); check("R1 hold read2", v, 8'h5A);
        set_idx(8'hC3); wr_data(8'h77);
        set_idx(8'd3); rd_data(v); check("R1 upper index bits ignored", v, 8'h77);
        set_idx(8'd20); rd_data(v); check("R1 other byte untouched", v, 8'h5A);

        // R5 R6: flags, request and clear on read.
        set_idx(8'd11); wr_data(8'h70);
        pulse_evt(3'b010);
        check("R5 irq on alarm", irq, 1);
        set_idx(8'd12); rd_data(v); check("R5 flag read alarm", v, 8'hA0);
        check("R6 irq after clear", irq, 0);
        rd_data(v); check("R6 flags cleared", v, 8'h00);
        set_idx(8'd11); wr_data(8'h20);
        pulse_evt(3'b100);
        check("R5 irq masked", irq, 0);
        set_idx(8'd12); rd_data(v); check("R5 periodic no enable", v, 8'h40);
        // R7: write to flag byte keeps flags.
        pulse_evt(3'b001);
        wr_data(8'h00);
        rd_data(v); check("R7 flag byte write ignored", v, 8'h10);
        // R6: event in the clearing cycle survives.
        pulse_evt(3'b001);
        @(negedge clk); data_rd = 1'b1; flag_set = 3'b010;
        @(negedge clk); data_rd = 1'b0; flag_set = 3'b000; v = rdata;
        check("R6 read before late event", v, 8'h10);
        check("R6 late event raises irq", irq, 1);
        rd_data(v); check("R6 late event kept", v, 8'hA0);
        // R7: write to valid byte has no effect.
        set_idx(8'd13); wr_data(8'hFF); vrt_in = 1'b0;
        rd_data(v); check("R7 valid byte write ignored", v, 8'h00);
        // R3: write to busy bit ignored.
        set_idx(8'd10); upd_busy = 1'b0; wr_data(8'hFF);
        rd_data(v); check("R3 busy bit not stored", v, 8'h7F);
        // R10: rdata holds without reads.
        set_idx(8'd11); repeat (3) @(negedge clk);
        check("R10 rdata held", rdata, 8'h7F);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule